// File: doc/BRIEF.md
# Message-Signaled Interrupt Doorbell Decoder

This block is a write-only doorbell window that turns posted bus writes into per-CPU interrupt requests. The write address alone picks both the destination CPU and the interrupt vector. Every accepted write sets one bit in that CPU's 256-bit pending-status row and raises that CPU's interrupt line. The write data, the address bits above the CPU field, and the low nibble play no part in the decode.

Software acknowledges an interrupt through a separate clear port that names a CPU and a vector. A CPU's interrupt line stays high while any bit in its row is set. Reads anywhere in the window complete one cycle later and return zero. The whole pending state is brought out on a flat status bus, so the CPU side can see which vectors are waiting.

Top module: `msi_doorbell`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and drives every `irq_o` bit and `rd_resp_valid` low.
- R2: A write accepted at a clock edge sets bit `vec` of CPU `cpu`'s row, where `vec = wr_addr[11:4]` and `cpu = wr_addr[19:12]`. The bit is visible on `pend_o[cpu*256 + vec]` right after that edge.
- R3: Every `irq_o[c]` is registered and equals the OR of `pend_o[c*256 +: 256]`. It rises right after the edge that accepts a write to CPU c.
- R4: `wr_data`, the tag bits `wr_addr[39:28]`, bits `wr_addr[27:20]` and bits `wr_addr[3:0]` have no effect on which bit is set.
- R5: A write whose CPU field is `NUM_CPU` or above is accepted and changes no pending bit and no interrupt line.
- R6: A clear strobe (`clr_valid` with `clr_cpu`, `clr_vec`) resets that one bit. When it clears the last set bit of a row, `irq_o` for that CPU falls right after the same edge. A clear naming a CPU at or above `NUM_CPU` changes nothing.
- R7: When a write and a clear target the same bit in the same cycle, the bit ends up set.
- R8: `wr_ready` is always high, and writes on consecutive cycles each take effect.
- R9: `rd_ready` is always high. Each read gets `rd_resp_valid` high with `rd_resp_data` zero in the cycle after it is accepted, and a read changes no pending state.
- R10: A write or a clear changes only the one bit it targets; all other CPUs and vectors keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_addr | input | 40 | Write address carrying tag, CPU and vector fields |
| wr_data | input | DATA_W | Write data, ignored |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accept, always high |
| rd_addr | input | 40 | Read address, ignored |
| rd_resp_valid | output | 1 | Read response strobe, one cycle after the request |
| rd_resp_data | output | DATA_W | Read response data, always zero |
| clr_valid | input | 1 | Acknowledge strobe |
| clr_cpu | input | 8 | CPU whose bit is cleared |
| clr_vec | input | 8 | Vector bit to clear |
| pend_o | output | NUM_CPU*256 | Pending-status rows, CPU c at bits c*256 upward |
| irq_o | output | NUM_CPU | Per-CPU interrupt line |

## Verification
The properties assume that every input is a defined value at each sampled edge outside reset. They also assume that a bit index built from an in-range CPU field lands inside `pend_o`. The bench drives all inputs from known values on the falling edge and leaves them idle at zero between operations. It also uses out-of-range CPU numbers only where R5 and R6 call for them, so the set and clear properties only ever meet in-range indices.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
  // Address field layout of the doorbell window (fixed by the message format)
  localparam int VEC_LSB = 4;
  localparam int VEC_W   = 8;
  localparam int CPU_LSB = 12;
  localparam int CPU_W   = 8;
  localparam int TAG_LSB = 28;
  localparam int TAG_W   = 12;
  localparam int ADDR_W  = TAG_LSB + TAG_W;
  localparam int NVEC    = 1 << VEC_W;

  function automatic logic [VEC_W-1:0] vec_field(input logic [ADDR_W-1:0] a);
    return a[VEC_LSB +: VEC_W];
  endfunction

  function automatic logic [CPU_W-1:0] cpu_field(input logic [ADDR_W-1:0] a);
    return a[CPU_LSB +: CPU_W];
  endfunction
endpackage

// File: rtl/msi_target_sel.sv
// One-hot CPU select; an index with no matching row yields all zeros.
module msi_target_sel #(
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 8
) (
  input  logic               valid,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_CPU-1:0] sel
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_sel
    assign sel[c] = valid && (idx == IDX_W'(c));
  end
endmodule

// File: rtl/msi_pend_row.sv
// One CPU's pending-status row plus its registered interrupt line.
module msi_pend_row #(
  parameter int VEC_W = 8,
  localparam int NV   = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [VEC_W-1:0] clr_vec,
  output logic [NV-1:0]    pend_q,
  output logic             irq_q
);
  logic [NV-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_vec] = 1'b0;
    // set applied last so a simultaneous set wins
    if (set_en) pend_d[set_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/msi_rd_zero.sv
// Read responder: every read completes next cycle with zero data.
module msi_rd_zero #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  always_ff @(posedge clk) begin
    if (rst) resp_valid <= 1'b0;
    else     resp_valid <= req;
  end
  assign resp_data = '0;
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_db_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  localparam int PEND_W = NUM_CPU * NVEC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_resp_valid,
  output logic [DATA_W-1:0]  rd_resp_data,
  input  logic               clr_valid,
  input  logic [CPU_W-1:0]   clr_cpu,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [PEND_W-1:0]  pend_o,
  output logic [NUM_CPU-1:0] irq_o
);
  logic [CPU_W-1:0]   wr_cpu;
  logic [VEC_W-1:0]   wr_vec;
  logic [NUM_CPU-1:0] wr_sel;
  logic [NUM_CPU-1:0] clr_sel;
  logic               wr_fire;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_cpu   = cpu_field(wr_addr);
  assign wr_vec   = vec_field(wr_addr);

  // Data, tag and spare address bits take no part in routing.
  logic unused_sink;
  assign unused_sink = ^{wr_data, wr_addr[ADDR_W-1:CPU_LSB+CPU_W],
                         wr_addr[VEC_LSB-1:0], rd_addr};

  msi_target_sel #(.NUM_CPU(NUM_CPU), .IDX_W(CPU_W)) u_wr_sel (
    .valid (wr_fire),
    .idx   (wr_cpu),
    .sel   (wr_sel)
  );

  msi_target_sel #(.NUM_CPU(NUM_CPU), .IDX_W(CPU_W)) u_clr_sel (
    .valid (clr_valid),
    .idx   (clr_cpu),
    .sel   (clr_sel)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_row
    msi_pend_row #(.VEC_W(VEC_W)) u_row (
      .clk     (clk),
      .rst     (rst),
      .set_en  (wr_sel[c]),
      .set_vec (wr_vec),
      .clr_en  (clr_sel[c]),
      .clr_vec (clr_vec),
      .pend_q  (pend_o[c*NVEC +: NVEC]),
      .irq_q   (irq_o[c])
    );
  end

  msi_rd_zero #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .req        (rd_valid && rd_ready),
    .resp_valid (rd_resp_valid),
    .resp_data  (rd_resp_data)
  );
endmodule

// File: rtl/msi_doorbell_chk.sv
module msi_doorbell_chk
  import msi_db_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  localparam int PEND_W = NUM_CPU * NVEC
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               rd_valid,
  input logic               rd_resp_valid,
  input logic [DATA_W-1:0]  rd_resp_data,
  input logic               clr_valid,
  input logic [CPU_W-1:0]   clr_cpu,
  input logic [VEC_W-1:0]   clr_vec,
  input logic [PEND_W-1:0]  pend_o,
  input logic [NUM_CPU-1:0] irq_o
);
  logic [CPU_W-1:0] w_cpu;
  logic [VEC_W-1:0] w_vec;
  int  w_idx, c_idx;
  logic w_in, c_in;

  assign w_cpu = wr_addr[CPU_LSB +: CPU_W];
  assign w_vec = wr_addr[VEC_LSB +: VEC_W];
  assign w_idx = int'(w_cpu) * NVEC + int'(w_vec);
  assign c_idx = int'(clr_cpu) * NVEC + int'(clr_vec);
  assign w_in  = int'(w_cpu) < NUM_CPU;
  assign c_in  = int'(clr_cpu) < NUM_CPU;

  // R2: an in-range write leaves its bit set
  a_r2_write_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && w_in) |=> pend_o[$past(w_idx)]);

  // R3: each interrupt line tracks the OR of its row
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    a_r3_irq_or: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] == (|pend_o[c*NVEC +: NVEC]));
  end

  // R5: an out-of-range write with no clear leaves all state alone
  a_r5_drop_far_cpu: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !w_in && !clr_valid) |=> $stable(pend_o));

  // R6, R7: a clear not met by a write to the same bit removes it
  a_r6_clear_bit: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && c_in && !(wr_valid && w_in && w_idx == c_idx))
      |=> !pend_o[$past(c_idx)]);

  // R9: a read is answered next cycle with zero
  a_r9_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (rd_resp_valid && rd_resp_data == '0));
endmodule

bind msi_doorbell msi_doorbell_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .rd_valid      (rd_valid),
  .rd_resp_valid (rd_resp_valid),
  .rd_resp_data  (rd_resp_data),
  .clr_valid     (clr_valid),
  .clr_cpu       (clr_cpu),
  .clr_vec       (clr_vec),
  .pend_o        (pend_o),
  .irq_o         (irq_o)
);

// File: tb/msi_doorbell_bench.sv
`timescale 1ns/1ps
module msi_doorbell_bench;
  import msi_db_pkg::*;
  localparam int NUM_CPU = 4;
  localparam int DATA_W  = 64;
  localparam int PEND_W  = NUM_CPU * NVEC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1;
  logic               wr_valid = 1'b0, wr_ready;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic               rd_valid = 1'b0, rd_ready;
  logic [ADDR_W-1:0]  rd_addr = '0;
  logic               rd_resp_valid;
  logic [DATA_W-1:0]  rd_resp_data;
  logic               clr_valid = 1'b0;
  logic [CPU_W-1:0]   clr_cpu = '0;
  logic [VEC_W-1:0]   clr_vec = '0;
  logic [PEND_W-1:0]  pend_o;
  logic [NUM_CPU-1:0] irq_o;

  msi_doorbell #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_msi_doorbell (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .clr_valid(clr_valid), .clr_cpu(clr_cpu), .clr_vec(clr_vec),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [PEND_W-1:0] exp_pend = '0;
  logic [DATA_W-1:0] rd_q[$];

  function automatic logic [ADDR_W-1:0] mk_addr(logic [11:0] tag, logic [7:0] mid,
                                                logic [7:0] cpu, logic [7:0] vec, logic [3:0] low);
    return {tag, mid, cpu, vec, low};
  endfunction

  function automatic logic [NUM_CPU-1:0] exp_irq();
    logic [NUM_CPU-1:0] r;
    for (int c = 0; c < NUM_CPU; c++) r[c] = |exp_pend[c*NVEC +: NVEC];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [PEND_W-1:0] act, logic [PEND_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, "pending rows", pend_o, exp_pend);
    chk(req, "irq lines", PEND_W'(irq_o), PEND_W'(exp_irq()));
  endtask

  // Driver: one cycle with optional write and optional clear; model updated at the edge
  task automatic step(bit s, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                      bit c, logic [7:0] cc, logic [7:0] cv);
    wr_valid = s; wr_addr = a; wr_data = d;
    clr_valid = c; clr_cpu = cc; clr_vec = cv;
    @(posedge clk);
    if (c && int'(cc) < NUM_CPU) exp_pend[int'(cc)*NVEC + int'(cv)] = 1'b0;
    if (s && int'(a[19:12]) < NUM_CPU) exp_pend[int'(a[19:12])*NVEC + int'(a[11:4])] = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; clr_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] cpu, logic [7:0] vec, logic [DATA_W-1:0] d);
    step(1'b1, mk_addr(12'h000, 8'h00, cpu, vec, 4'h0), d, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic clr(logic [7:0] cpu, logic [7:0] vec);
    step(1'b0, '0, '0, 1'b1, cpu, vec);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    rd_valid = 1'b1; rd_addr = a;
    rd_q.push_back('0);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // Monitor: pop expected read responses as they appear (R9)
  always @(negedge clk) begin
    if (!rst && rd_resp_valid) begin
      n_run++;
      if (rd_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected read response: actual valid 1 expected none");
      end else begin
        logic [DATA_W-1:0] e;
        e = rd_q.pop_front();
        if (rd_resp_data !== e) begin
          n_fail++;
          $display("FAIL R9 read data: actual %h expected %h", rd_resp_data, e);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    exp_pend = '0;
    chk_state("R1");
    chk("R1", "read resp valid", PEND_W'(rd_resp_valid), '0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R8: ready is high
    chk("R8", "wr_ready", PEND_W'(wr_ready), PEND_W'(1));
    chk("R9", "rd_ready", PEND_W'(rd_ready), PEND_W'(1));

    // R2, R3: basic writes
    wr(8'd0, 8'd5, 64'hDEAD_BEEF_0000_0001);
    chk_state("R2");
    wr(8'd2, 8'd0, 64'h0);
    chk_state("R3");

    // R4: tag, spare bits and data do not steer the write
    step(1'b1, mk_addr(12'hFFF, 8'hA5, 8'd3, 8'd255, 4'hF), 64'hFFFF_FFFF_FFFF_FFFF,
         1'b0, 8'h00, 8'h00);
    chk_state("R4");
    step(1'b1, mk_addr(12'h123, 8'h5A, 8'd3, 8'd128, 4'h9), 64'h0123_4567_89AB_CDEF,
         1'b0, 8'h00, 8'h00);
    chk_state("R4");

    // R5: CPU index out of range is dropped
    wr(8'd4, 8'd1, 64'h1);
    chk_state("R5");
    wr(8'd200, 8'd77, 64'h2);
    chk_state("R5");

    // R8: back-to-back writes to CPU 1
    wr(8'd1, 8'd10, 64'h0);
    wr(8'd1, 8'd11, 64'h0);
    chk_state("R8");

    // R6, R10: clears; CPU 1 keeps irq while one bit remains
    clr(8'd1, 8'd10);
    chk_state("R10");
    clr(8'd0, 8'd5);
    chk_state("R6");
    clr(8'd1, 8'd11);
    chk_state("R6");
    clr(8'd7, 8'd0);
    chk_state("R6");

    // R7: set and clear on the same bit in one cycle, bit clear and bit set before
    step(1'b1, mk_addr(12'h000, 8'h00, 8'd2, 8'd7, 4'h0), '0, 1'b1, 8'd2, 8'd7);
    chk_state("R7");
    step(1'b1, mk_addr(12'h000, 8'h00, 8'd2, 8'd7, 4'h0), '0, 1'b1, 8'd2, 8'd7);
    chk_state("R7");
    // write one CPU while clearing another in the same cycle
    step(1'b1, mk_addr(12'h000, 8'h00, 8'd0, 8'd200, 4'h0), '0, 1'b1, 8'd3, 8'd255);
    chk_state("R10");

    // R9: reads return zero and touch nothing
    rd(mk_addr(12'hFFF, 8'h00, 8'd0, 8'd200, 4'h0));
    rd(mk_addr(12'h000, 8'h11, 8'd1, 8'd3, 4'h4));
    @(negedge clk);
    chk_state("R9");

    // R1: reset in the middle of activity
    do_reset();
    chk("R9", "outstanding reads", PEND_W'(rd_q.size()), '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule